// File: doc/BRIEF.md
# Triggered Ring-Buffer Capture Controller

This block steers sample capture for a digital storage oscilloscope. Once armed, it streams every valid sample word into an external synchronous SRAM, one write per clock. The SRAM is used as a circular buffer, so the oldest history is overwritten when the pointer wraps. The analog channel codes and the logic-analyser bits of a sample are packed into a single memory word before they are written.

A trigger is taken only together with a valid sample. That sample is written, and then a programmed number of further samples are stored. After the last of these the controller stops writing. It raises a done flag and keeps the address of the final write, so that software can locate the pre-trigger history (the words that follow that address) and the post-trigger history (the words up to it). While the controller is idle or done it issues no writes, which leaves the memory free for a readout path outside this block.

Top module: `acq_ring_capture`

## Requirements
- R1: A synchronous reset clears armed, triggered and done. It sets the write address and the stop address to zero.
- R2: While armed, every cycle with sample-valid high produces exactly one write at the current address. The address then advances by one. Cycles without a valid sample write nothing and leave the address unchanged.
- R3: After a write at address DEPTH-1 the address returns to 0, for any DEPTH including DEPTH values that are not a power of two.
- R4: A trigger is accepted only while armed, not yet triggered, and with sample-valid high. A trigger outside those conditions leaves every flag unchanged.
- R5: The post-trigger count N is sampled together with the accepted trigger. Exactly N further valid samples are then written, after which armed falls and no write occurs until the controller is armed again.
- R6: Done rises in the cycle after the last write. From that cycle on, the stop address equals the address of that last write.
- R7: With N equal to 0, the trigger sample is the last write.
- R8: No write occurs while idle or done, whatever the sample, trigger and valid inputs do.
- R9: In the memory word, analog channel k occupies bits [k*CH_W +: CH_W]. The digital inputs occupy bits [NUM_CH*CH_W +: DIG_W]. Any bits above these are written as zero.
- R10: An arm pulse in the idle or done state sets armed and clears triggered and done on the next cycle. An arm pulse while armed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Arm pulse, starts a new capture |
| post_cnt_i | input | CNT_W | Number of samples to store after the trigger sample |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_ana_i | input | NUM_CH*CH_W | Analog channel codes, channel 0 in the low bits |
| smp_dig_i | input | DIG_W | Logic-analyser input bits |
| trig_i | input | 1 | Trigger event from the external comparator |
| mem_addr_o | output | ADDR_W | SRAM write address |
| mem_data_o | output | WORD_W | SRAM write data |
| mem_we_o | output | 1 | SRAM write enable |
| armed_o | output | 1 | Capture in progress |
| triggered_o | output | 1 | Trigger accepted in this capture |
| done_o | output | 1 | Capture finished |
| stop_addr_o | output | ADDR_W | Address of the final write |

## Verification
On every cycle, the in-line properties check the following:
- no write is issued outside the armed states;
- the address holds when nothing is written and wraps to zero after the top word;
- the trigger flag can rise only from an armed, untriggered state with a valid trigger sample;
- the remaining-count register never underflows;
- done rises only after a write, and the stop address matches that write.

Only the bench scenarios show that the number of post-trigger writes is exactly the programmed count, including zero. They also show that packed data reaches the right bit fields, that triggers arriving early, late or without a valid sample are ignored, and that re-arming after done starts a clean capture.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } acq_state_t;
endpackage

// File: rtl/acq_word_pack.sv
module acq_word_pack #(
   parameter int NUM_CH = 2,
   parameter int CH_W   = 10,
   parameter int DIG_W  = 16,
   parameter int WORD_W = 36
) (
   input  logic [NUM_CH*CH_W-1:0] ana_i,
   input  logic [DIG_W-1:0]       dig_i,
   output logic [WORD_W-1:0]      word_o
);
   localparam int ANA_W = NUM_CH * CH_W;
   localparam int USED  = ANA_W + DIG_W;
   localparam int PAD   = WORD_W - USED;

   if (NUM_CH < 1 || CH_W < 1 || DIG_W < 1) begin : g_bad_field
      $error("acq_word_pack: every field needs a width of at least one");
   end
   if (USED > WORD_W) begin : g_bad_fit
      $error("acq_word_pack: channels and digital bits exceed the word");
   end

   // R9: channel k sits at [k*CH_W +: CH_W]
   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign word_o[k*CH_W +: CH_W] = ana_i[k*CH_W +: CH_W];
   end
   assign word_o[ANA_W +: DIG_W] = dig_i;

   if (PAD > 0) begin : g_pad
      assign word_o[WORD_W-1:USED] = '0;
   end
endmodule

// File: rtl/acq_wr_ptr.sv
module acq_wr_ptr #(
   parameter int DEPTH  = 524288,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);
   localparam bit POW2 = (DEPTH == (1 << ADDR_W));

   if (DEPTH < 2) begin : g_bad_depth
      $error("acq_wr_ptr: DEPTH must be at least 2");
   end

   logic [ADDR_W-1:0] ptr_q;

   if (POW2) begin : g_pow2
      // wrap comes free from the adder width
      always_ff @(posedge clk) begin
         if (rst)        ptr_q <= '0;
         else if (adv_i) ptr_q <= ptr_q + 1'b1;
      end
   end else begin : g_mod
      always_ff @(posedge clk) begin
         if (rst)          ptr_q <= '0;
         else if (adv_i)   ptr_q <= (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(ptr_o));
   p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      (adv_i && ptr_o == TOP) |=> ptr_o == '0);
   p_range_r3: assert property (@(posedge clk) disable iff (rst)
      ptr_o <= TOP);
endmodule

// File: rtl/acq_post_ctr.sv
module acq_post_ctr #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             last_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == CNT_W'(1));

   p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
      dec_i |-> cnt_q != '0);
   p_load_r5: assert property (@(posedge clk) disable iff (rst)
      load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/acq_ring_capture.sv
module acq_ring_capture
   import acq_pkg::*;
#(
   parameter int DEPTH  = 524288,
   parameter int WORD_W = 36,
   parameter int NUM_CH = 2,
   parameter int CH_W   = 10,
   parameter int DIG_W  = 16,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int CNT_W  = ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   arm_i,
   input  logic [CNT_W-1:0]       post_cnt_i,
   input  logic                   smp_valid_i,
   input  logic [NUM_CH*CH_W-1:0] smp_ana_i,
   input  logic [DIG_W-1:0]       smp_dig_i,
   input  logic                   trig_i,
   output logic [ADDR_W-1:0]      mem_addr_o,
   output logic [WORD_W-1:0]      mem_data_o,
   output logic                   mem_we_o,
   output logic                   armed_o,
   output logic                   triggered_o,
   output logic                   done_o,
   output logic [ADDR_W-1:0]      stop_addr_o
);
   if (ADDR_W < $clog2(DEPTH)) begin : g_bad_addr
      $error("acq_ring_capture: ADDR_W too narrow for DEPTH");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("acq_ring_capture: CNT_W must be positive");
   end

   acq_state_t        st_q, st_d;
   logic [ADDR_W-1:0] ptr;
   logic [ADDR_W-1:0] stop_q;
   logic              armed, wr, trig_take, zero_post, last, finish;

   assign armed     = (st_q == ST_PRE) || (st_q == ST_POST);
   assign wr        = armed && smp_valid_i;
   assign trig_take = (st_q == ST_PRE) && smp_valid_i && trig_i;
   assign zero_post = (post_cnt_i == '0);
   assign finish    = (trig_take && zero_post) ||
                      ((st_q == ST_POST) && wr && last);

   acq_word_pack #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .DIG_W  (DIG_W),
      .WORD_W (WORD_W)
   ) u_pack (
      .ana_i  (smp_ana_i),
      .dig_i  (smp_dig_i),
      .word_o (mem_data_o)
   );

   acq_wr_ptr #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) u_ptr (
      .clk   (clk),
      .rst   (rst),
      .adv_i (wr),
      .ptr_o (ptr)
   );

   acq_post_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .load_i     (trig_take),
      .load_val_i (post_cnt_i),
      .dec_i      ((st_q == ST_POST) && wr),
      .last_o     (last)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: if (arm_i) st_d = ST_PRE;
         ST_PRE:  if (trig_take) st_d = zero_post ? ST_DONE : ST_POST;
         ST_POST: if (finish)    st_d = ST_DONE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         stop_q <= '0;
      end else begin
         st_q <= st_d;
         if (finish) stop_q <= ptr;
      end
   end

   assign mem_addr_o  = ptr;
   assign mem_we_o    = wr;
   assign armed_o     = armed;
   assign triggered_o = (st_q == ST_POST) || (st_q == ST_DONE);
   assign done_o      = (st_q == ST_DONE);
   assign stop_addr_o = stop_q;

   p_no_we_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !armed_o |-> !mem_we_o);
   p_trig_gate_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(triggered_o) |-> $past(armed_o && !triggered_o && trig_i && smp_valid_i));
   p_done_after_we_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> $past(mem_we_o));
   p_stop_addr_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(done_o) |-> stop_addr_o == $past(mem_addr_o));
   p_arm_r10: assert property (@(posedge clk) disable iff (rst)
      (arm_i && !armed_o) |=> armed_o && !triggered_o && !done_o);
   p_armed_stays_r10: assert property (@(posedge clk) disable iff (rst)
      (armed_o && !mem_we_o) |=> armed_o);
endmodule

// File: tb/acq_ring_capture_tb_top.sv
module acq_ring_capture_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 48;
   localparam int WORD_W = 36;
   localparam int NUM_CH = 2;
   localparam int CH_W   = 10;
   localparam int DIG_W  = 16;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int CNT_W  = ADDR_W;

   logic                   clk = 1'b0;
   logic                   rst;
   logic                   arm_i;
   logic [CNT_W-1:0]       post_cnt_i;
   logic                   smp_valid_i;
   logic [NUM_CH*CH_W-1:0] smp_ana_i;
   logic [DIG_W-1:0]       smp_dig_i;
   logic                   trig_i;
   logic [ADDR_W-1:0]      mem_addr_o;
   logic [WORD_W-1:0]      mem_data_o;
   logic                   mem_we_o;
   logic                   armed_o, triggered_o, done_o;
   logic [ADDR_W-1:0]      stop_addr_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   acq_ring_capture #(
      .DEPTH (DEPTH), .WORD_W (WORD_W), .NUM_CH (NUM_CH),
      .CH_W (CH_W), .DIG_W (DIG_W)
   ) dut_i (
      .clk (clk), .rst (rst), .arm_i (arm_i), .post_cnt_i (post_cnt_i),
      .smp_valid_i (smp_valid_i), .smp_ana_i (smp_ana_i), .smp_dig_i (smp_dig_i),
      .trig_i (trig_i), .mem_addr_o (mem_addr_o), .mem_data_o (mem_data_o),
      .mem_we_o (mem_we_o), .armed_o (armed_o), .triggered_o (triggered_o),
      .done_o (done_o), .stop_addr_o (stop_addr_o)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 0;
   bit running  = 0;
   bit exp_we   = 0;
   logic [ADDR_W+WORD_W-1:0] exp_q[$];

   // requirement model state: 0 idle, 1 pre, 2 post, 3 done
   int m_st = 0;
   int m_ptr = 0;
   int m_rem = 0;
   int m_stop = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares the write port against the scoreboard queue
   always @(negedge clk) begin
      if (running) begin
         check(mem_we_o == exp_we, "R2 R8 write enable", mem_we_o, exp_we);
         if (mem_we_o && exp_q.size() > 0) begin
            logic [ADDR_W+WORD_W-1:0] e;
            e = exp_q.pop_front();
            check(mem_addr_o == e[ADDR_W+WORD_W-1:WORD_W], "R2 R3 address",
                  mem_addr_o, e[ADDR_W+WORD_W-1:WORD_W]);
            check(mem_data_o == e[WORD_W-1:0], "R9 data packing",
                  mem_data_o, e[WORD_W-1:0]);
         end
      end
   end

   task automatic flags();
      check(armed_o == (m_st == 1 || m_st == 2), "R5 R10 armed", armed_o, (m_st == 1 || m_st == 2));
      check(triggered_o == (m_st >= 2), "R4 triggered", triggered_o, (m_st >= 2));
      check(done_o == (m_st == 3), "R6 done", done_o, (m_st == 3));
      check(stop_addr_o == ADDR_W'(m_stop), "R6 stop address", stop_addr_o, m_stop);
      check(mem_addr_o == ADDR_W'(m_ptr), "R3 pointer", mem_addr_o, m_ptr);
   endtask

   task automatic step(input bit v, input bit t, input bit a, input int pc,
                       input logic [19:0] ana, input logic [15:0] dig);
      logic [WORD_W-1:0] w;
      smp_valid_i = v; trig_i = t; arm_i = a;
      post_cnt_i = CNT_W'(pc); smp_ana_i = ana; smp_dig_i = dig;
      exp_we = (m_st == 1 || m_st == 2) && v;
      if (exp_we) begin
         w = '0;
         w[9:0]   = ana[9:0];    // R9: channel 0
         w[19:10] = ana[19:10];  // R9: channel 1
         w[35:20] = dig;
         exp_q.push_back({ADDR_W'(m_ptr), w});
      end
      @(posedge clk); #1;
      case (m_st)
         0, 3: if (a) m_st = 1;
         1: if (v && t) begin
               if (pc == 0) begin m_st = 3; m_stop = m_ptr; end
               else begin m_rem = pc; m_st = 2; end
            end
         2: if (v) begin
               if (m_rem == 1) begin m_st = 3; m_stop = m_ptr; end
               else m_rem--;
            end
         default: ;
      endcase
      if (exp_we) m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
      flags();
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; arm_i = 0; post_cnt_i = '0; smp_valid_i = 0;
      smp_ana_i = '0; smp_dig_i = '0; trig_i = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(!armed_o && !triggered_o && !done_o, "R1 flags", {armed_o, triggered_o, done_o}, 0);
      check(mem_addr_o == '0, "R1 pointer", mem_addr_o, 0);
      check(stop_addr_o == '0, "R1 stop", stop_addr_o, 0);
      rst = 1'b0;
      running = 1;

      // R8 R4: idle samples and triggers write nothing
      for (int i = 0; i < 4; i++) step(1, i[0], 0, 2, 20'(i * 7 + 1), 16'hA000 + 16'(i));
      step(1, 0, 1, 0, 20'h11111, 16'h1111);                 // R10: arm
      for (int i = 0; i < 6; i++) step(i != 2, 0, 0, 0, 20'(32'h3F00 + i * 13), 16'(i * 257));
      step(0, 1, 0, 3, 20'hFFFFF, 16'hFFFF);                 // R4: trigger without valid ignored
      step(1, 0, 1, 3, 20'h5A5A5, 16'h0F0F);                 // R10: arm while armed ignored
      step(1, 1, 0, 5, 20'hC3C3C, 16'hBEEF);                 // trigger, N=5 (R5)
      for (int i = 0; i < 8; i++) step(i % 3 != 1, 1, 0, 1, 20'(32'h800 + i), 16'(i));  // R4: late triggers ignored
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 20'hABCDE, 16'h1234);               // R8: done, no writes

      // R3 R7: re-arm, wrap past DEPTH-1, then N=0
      step(1, 0, 1, 0, 20'h0, 16'h0);
      for (int i = 0; i < 60; i++) step(1, 0, 0, 0, 20'(32'h10000 + i * 99), 16'(~i));
      step(1, 1, 0, 0, 20'h76543, 16'hCAFE);                 // R7: zero post count
      step(1, 0, 0, 0, 20'h1, 16'h1);
      step(1, 1, 0, 0, 20'h2, 16'h2);

      // R5: post count of three with a second trigger inside the window
      step(0, 0, 1, 0, 20'h0, 16'h0);
      for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 20'(i), 16'hF000);
      step(1, 1, 0, 3, 20'h0000F, 16'h00F0);
      step(1, 1, 0, 0, 20'h000F0, 16'h0F00);
      for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 20'(32'hF0000 + i), 16'(i));

      exp_we = 0;
      running = 0;
      check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule